// File: doc/BRIEF.md
# Four-Channel DMA Round-Robin Arbiter

This block decides which of four DMA channels owns the transfer engine. Each channel raises a request line, and the arbiter issues a one-hot grant to one of them. The transfer engine then pulses a done strobe when the granted transfer completes. Arbitration is non-preemptive. A grant, once issued, holds until its done strobe arrives. Requests that come in while a transfer is running are stored and compete at the next boundary.

Priority is kept as a pointer to the channel that currently ranks highest. The remaining channels follow in ascending order, modulo four. When a transfer finishes, the pointer moves to the channel numbered one above the finished one, so the finished channel ranks last. The full ranking is brought out on a debug port so that software-visible tools can watch the rotation.

Top module: `rr_dma_arb`

## Requirements
- R1: A synchronous active-high reset clears every stored request and the grant, drives grant_vld_o low, and sets the ranking to 0 > 1 > 2 > 3.
- R2: grant_o has at most one bit set. grant_vld_o is high exactly when grant_o is non-zero. While grant_vld_o is high, grant_idx_o equals the index of the set bit.
- R3: When several channels are pending at a decision point, the grant goes to the pending channel that ranks highest in the current order.
- R4: While a grant is valid and done_i is low, grant_o and grant_idx_o do not change, even if other channels request.
- R5: On a done_i pulse while a grant is valid, the ranking becomes (finished+1) mod 4 highest, then ascending, with the finished channel lowest. prio_order_o holds the channel of rank k in bits [2k+1:2k], with rank 0 highest; after reset it reads 8'hE4.
- R6: A request pulse of a single cycle, arriving during another channel's transfer, is stored and later granted.
- R7: A request seen at clock edge n while idle gives a grant after edge n+1. A done_i seen at edge n drops grant_vld_o after edge n. The next grant appears after edge n+1.
- R8: When nothing is pending, grant_vld_o stays low and the ranking is unchanged.
- R9: A done_i pulse while no grant is valid has no effect on the ranking or the grant.
- R10: A channel's stored request is cleared when its grant is issued, so one request pulse yields exactly one grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Per-channel transfer request |
| done_i | input | 1 | Transfer-complete strobe from the transfer engine |
| grant_o | output | 4 | One-hot grant, registered |
| grant_vld_o | output | 1 | A grant is active |
| grant_idx_o | output | 2 | Index of the granted channel |
| prio_order_o | output | 8 | Channel at each rank, rank 0 in the low bits |

## Verification
A corrupted head pointer shows on prio_order_o in the cycle after the faulty done_i. It also shows at the next decision point as a grant to the wrong channel of a multi-channel request set. A lost or stuck stored request shows as a missing grant, or an extra grant, one cycle after the preceding transfer ends. Grant register faults are visible at once as a non-one-hot grant_o, or as a grant that moves before its done strobe.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

  // Channel index reached by stepping 'step' places up from 'base', wrapping at n.
  function automatic int wrap_step(input int base, input int step, input int n);
    return (base + step) % n;
  endfunction

endpackage

// File: rtl/rr_pending.sv
module rr_pending #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] pend_o
);

  logic [NUM_CH-1:0] pend_q;

  // Clearing wins over a request arriving in the grant cycle.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q | req_i) & ~clr_i;
  end

  assign pend_o = pend_q;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_chk
      AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((pend_q[g] || req_i[g]) && !clr_i[g]) |=> pend_q[g]);            // R6
      AST_CLEAR_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
        clr_i[g] |=> !pend_q[g]);                                         // R10
    end
  endgenerate

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [IDX_W-1:0]  head_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  win_idx_o,
  output logic [NUM_CH-1:0] win_oh_o
);
  import rr_arb_pkg::*;

  // Walk the ranks from highest to lowest; the first pending channel wins.
  always_comb begin
    any_o     = 1'b0;
    win_idx_o = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (!any_o && pend_i[wrap_step(int'(head_i), k, NUM_CH)]) begin
        any_o     = 1'b1;
        win_idx_o = IDX_W'(wrap_step(int'(head_i), k, NUM_CH));
      end
    end
    win_oh_o = any_o ? (NUM_CH'(1) << win_idx_o) : '0;
  end

endmodule

// File: rtl/rr_grant_ctl.sv
module rr_grant_ctl #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  win_idx_i,
  input  logic [NUM_CH-1:0] win_oh_i,
  input  logic              done_i,
  output logic [NUM_CH-1:0] clr_o,
  output logic [NUM_CH-1:0] grant_o,
  output logic              vld_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [IDX_W-1:0]  head_o
);

  logic              vld_q;
  logic [NUM_CH-1:0] grant_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  head_q;
  logic              issue;
  logic              finish;

  assign issue  = !vld_q && any_i;
  assign finish = vld_q && done_i;
  assign clr_o  = issue ? win_oh_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      grant_q <= '0;
      idx_q   <= '0;
      head_q  <= '0;
    end else if (finish) begin
      vld_q   <= 1'b0;
      grant_q <= '0;
      idx_q   <= '0;
      head_q  <= (int'(idx_q) == NUM_CH - 1) ? '0 : idx_q + 1'b1;
    end else if (issue) begin
      vld_q   <= 1'b1;
      grant_q <= win_oh_i;
      idx_q   <= win_idx_i;
    end
  end

  assign grant_o = grant_q;
  assign vld_o   = vld_q;
  assign idx_o   = idx_q;
  assign head_o  = head_q;

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q) && (vld_q == (grant_q != '0)));                     // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !done_i) |=> (vld_q && $stable(grant_q) && $stable(idx_q))); // R4
  AST_GAP: assert property (@(posedge clk) disable iff (rst)
    finish |=> !vld_q);                                                    // R7
  AST_HEAD_KEEP: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(head_q));                                          // R9

endmodule

// File: rtl/rr_dma_arb.sv
module rr_dma_arb #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       req_i,
  input  logic                    done_i,
  output logic [NUM_CH-1:0]       grant_o,
  output logic                    grant_vld_o,
  output logic [IDX_W-1:0]        grant_idx_o,
  output logic [NUM_CH*IDX_W-1:0] prio_order_o
);
  import rr_arb_pkg::*;

  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] clr;
  logic [NUM_CH-1:0] win_oh;
  logic [IDX_W-1:0]  win_idx;
  logic [IDX_W-1:0]  head;
  logic              any;

  rr_pending #(.NUM_CH(NUM_CH)) u_pend (
    .clk(clk), .rst(rst), .req_i(req_i), .clr_i(clr), .pend_o(pend)
  );

  rr_pick #(.NUM_CH(NUM_CH)) u_pick (
    .pend_i(pend), .head_i(head), .any_o(any),
    .win_idx_o(win_idx), .win_oh_o(win_oh)
  );

  rr_grant_ctl #(.NUM_CH(NUM_CH)) u_ctl (
    .clk(clk), .rst(rst), .any_i(any), .win_idx_i(win_idx),
    .win_oh_i(win_oh), .done_i(done_i), .clr_o(clr),
    .grant_o(grant_o), .vld_o(grant_vld_o), .idx_o(grant_idx_o),
    .head_o(head)
  );

  genvar r;
  generate
    for (r = 0; r < NUM_CH; r++) begin : g_rank
      assign prio_order_o[r*IDX_W +: IDX_W] = IDX_W'(wrap_step(int'(head), r, NUM_CH));
    end
  endgenerate

  AST_ROT_LAST: assert property (@(posedge clk) disable iff (rst)
    (grant_vld_o && done_i) |=>
      (prio_order_o[(NUM_CH-1)*IDX_W +: IDX_W] == $past(grant_idx_o)));    // R5
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst)
    (!grant_vld_o && any) |=> (grant_vld_o && ((grant_o & $past(pend)) != '0))); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!grant_vld_o && pend == '0) |=> !grant_vld_o);                        // R8

endmodule

// File: tb/rr_dma_arb_test.sv
module rr_dma_arb_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0;
  logic       done = 1'b0;
  logic [3:0] grant;
  logic       vld;
  logic [1:0] gidx;
  logic [7:0] order;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rr_dma_arb uut (
    .clk(clk), .rst(rst), .req_i(req), .done_i(done),
    .grant_o(grant), .grant_vld_o(vld), .grant_idx_o(gidx),
    .prio_order_o(order)
  );

  function automatic logic [7:0] order_of(input int head);
    logic [7:0] o;
    for (int k = 0; k < 4; k++) o[k*2 +: 2] = 2'((head + k) % 4);
    return o;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_grant(input string rq, input int ch);
    chk({rq, " vld"}, int'(vld), 1);
    chk({rq, " grant"}, int'(grant), 1 << ch);
    chk({rq, " idx"}, int'(gidx), ch);
  endtask

  task automatic pulse_req(input logic [3:0] m);
    req = m;
    step();
    req = '0;
  endtask

  // done pulse; afterwards the grant is dropped and the order rotated
  task automatic finish_xfer(input int ch);
    done = 1'b1;
    step();
    done = 1'b0;
    chk("R7 gap after done", int'(vld), 0);
    chk("R5 order after done", int'(order), int'(order_of((ch + 1) % 4)));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req = '0;
    done = 1'b0;
    step();
    step();
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 vld", int'(vld), 0);
    chk("R1 grant", int'(grant), 0);
    chk("R1 order", int'(order), 8'hE4);
  endtask

  task automatic t_standby_sequence();
    pulse_req(4'b1001);
    chk("R7 no grant one edge after request", int'(vld), 0);
    step();
    expect_grant("R3 0 beats 3", 0);
    step();
    pulse_req(4'b0010);
    step();
    expect_grant("R4 held during transfer", 0);
    finish_xfer(0);
    step();
    expect_grant("R3 R6 1 beats 3 after rotation", 1);
    finish_xfer(1);
    chk("R5 order 2>3>0>1", int'(order), 8'h4E);
    step();
    expect_grant("R3 3 last", 3);
    finish_xfer(3);
    chk("R5 order back to 0>1>2>3", int'(order), 8'hE4);
    step();
    step();
    chk("R10 no repeat grant", int'(vld), 0);
    chk("R8 order unchanged when idle", int'(order), 8'hE4);
  endtask

  task automatic t_stray_done();
    done = 1'b1;
    step();
    done = 1'b0;
    step();
    chk("R9 order after stray done", int'(order), 8'hE4);
    chk("R9 vld after stray done", int'(vld), 0);
  endtask

  task automatic t_wrap_rotation();
    pulse_req(4'b0100);
    step();
    expect_grant("R7 single request", 2);
    finish_xfer(2);
    chk("R5 order 3>0>1>2", int'(order), 8'h93);
    pulse_req(4'b1111);
    step();
    expect_grant("R3 head 3 wins", 3);
    for (int n = 0; n < 3; n++) begin
      finish_xfer((n + 3) % 4);
      step();
      expect_grant("R3 R10 round robin walk", n);
    end
    finish_xfer(2);
    step();
    chk("R10 all four served once", int'(vld), 0);
  endtask

  task automatic t_reset_mid_transfer();
    pulse_req(4'b0001);
    step();
    expect_grant("R2 grant before reset", 0);
    pulse_req(4'b0110);
    do_reset();
    chk("R1 grant cleared", int'(grant), 0);
    chk("R1 order reset", int'(order), 8'hE4);
    step();
    step();
    chk("R1 pending cleared", int'(vld), 0);
  endtask

  initial begin
    t_reset_state();
    t_standby_sequence();
    t_stray_done();
    t_wrap_rotation();
    t_reset_mid_transfer();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule